// File: doc/BRIEF.md
# Sealable Instruction Intake Gate

This block is the entry stage for instruction words of a programmable port controller. Dispatched words arrive on a valid/ready input. Each word is 37 bits wide: a 26-bit instruction in bits 36..11 and an 11-bit routing path in bits 10..0. The routing path has no meaning once the word has arrived, so it is discarded. A gate with two states, open or sealed, decides whether instructions may continue into the downstream instruction queue. The stream toward that queue is also valid/ready and carries only the 26-bit instruction.

A tail instruction seals the gate and is consumed at the intake without going downstream. While the gate is sealed, later instructions collect in a small epilogue buffer. An `unseal` pulse, raised by the execution side whenever its outer loop count reaches zero, reopens the gate. The buffered instructions then drain in arrival order before any newer word. An arrival marked as a payload-free token is a kill request. It is recognised ahead of the epilogue buffer and raises a kill-pending flag, which stays set until the execution stage acknowledges it.

Top module: `intake_gate`

## Requirements
- R1: After reset the gate is open, the epilogue buffer is empty, `kill_pending` is 0 and `out_valid` is 0 while `in_valid` is 0.
- R2: While the gate is open and the epilogue buffer is empty, a plain instruction word (`in_token`=0 and opcode `in_word[36:35]` not 2'b11) passes through in the same cycle: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_instr` equals the instruction field.
- R3: A word with opcode `in_word[36:35]`=2'b11 is a tail. It is accepted whenever the gate is sealed or the epilogue buffer is empty. It seals the gate from the next cycle and never appears on the output.
- R4: While the gate is sealed, `out_valid` is 0. Plain words are stored in the epilogue buffer, which holds 4 entries, and `in_ready` for a plain word is 0 when the buffer is full.
- R5: An `unseal` pulse opens the gate from the next cycle. Stored words then leave in arrival order, ahead of any word arriving later, and new plain words queue behind them while the buffer is not empty.
- R6: When a tail is accepted in the same cycle as an `unseal` pulse, the gate ends up sealed.
- R7: A word with `in_token`=1 is a kill request. It is accepted whenever `kill_pending` is 0, even with the gate sealed and the buffer full. It sets `kill_pending` in the next cycle and is neither stored nor output.
- R8: `kill_pending` stays 1 until a cycle with `kill_ack`=1 and is 0 from the cycle after that. While it is 1, a further token sees `in_ready`=0.
- R9: A tail that arrives while the gate is open and the buffer still holds words sees `in_ready`=0 until the buffer has drained.
- R10: The routing path bits 10..0 have no effect on `out_instr` or on any control decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arrival valid |
| in_token | input | 1 | Arrival is a payload-free token (kill request) |
| in_word | input | 37 | Instruction in bits 36..11, routing path in bits 10..0 |
| in_ready | output | 1 | Arrival accepted when high together with in_valid |
| unseal | input | 1 | Pulse: outer loop count reached zero |
| out_valid | output | 1 | Instruction available toward the instruction queue |
| out_ready | input | 1 | Instruction queue accepts |
| out_instr | output | 26 | Instruction toward the instruction queue |
| kill_pending | output | 1 | A kill request is waiting for the execution stage |
| kill_ack | input | 1 | Execution stage has taken the kill request |

## Verification
The case that is hardest to reach is a tail that arrives while the gate is open but stored words are still waiting. That state exists only in the cycles after an unseal, before the epilogue buffer drains. The stimulus reaches it with a directed sequence: seal, store two words, unseal while holding `out_ready` low, and then present the tail. A randomized phase then mixes tails, tokens, unseal pulses, acknowledgments and back-pressure. It checks every output against a queue and a seal model kept in the bench.

// File: rtl/intake_pkg.sv
package intake_pkg;

  localparam int unsigned DEF_INSTR_W = 26;
  localparam int unsigned DEF_PATH_W  = 11;
  localparam int unsigned OP_W        = 2;
  localparam logic [OP_W-1:0] DEF_TAIL_OP = 2'b11;

  typedef enum logic [1:0] {
    ARR_NONE  = 2'd0,
    ARR_WORD  = 2'd1,
    ARR_TAIL  = 2'd2,
    ARR_TOKEN = 2'd3
  } arrival_e;

  // Sort one arrival into its kind; a token wins over any word contents.
  function automatic arrival_e classify(input logic valid, input logic token,
                                        input logic [OP_W-1:0] op,
                                        input logic [OP_W-1:0] tail_op);
    if (!valid)             return ARR_NONE;
    else if (token)         return ARR_TOKEN;
    else if (op == tail_op) return ARR_TAIL;
    else                    return ARR_WORD;
  endfunction

  // Gate state: sealing beats reopening in the same cycle.
  function automatic logic seal_next(input logic sealed, input logic tail_acc,
                                     input logic unseal);
    if (tail_acc)    return 1'b1;
    else if (unseal) return 1'b0;
    else             return sealed;
  endfunction

  // Kill flag: set by an accepted token, cleared by acknowledgment.
  function automatic logic kill_next(input logic pending, input logic tok_acc,
                                     input logic ack);
    if (tok_acc)  return 1'b1;
    else if (ack) return 1'b0;
    else          return pending;
  endfunction

endpackage

// File: rtl/intake_decode.sv
module intake_decode
  import intake_pkg::*;
#(
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned PATH_W  = DEF_PATH_W,
  parameter logic [OP_W-1:0] TAIL_OP = DEF_TAIL_OP,
  localparam int unsigned WORD_W = INSTR_W + PATH_W
) (
  input  logic              in_valid,
  input  logic              in_token,
  input  logic [WORD_W-1:0] in_word,
  output arrival_e          kind,
  output logic [INSTR_W-1:0] instr
);

  logic [PATH_W-1:0] path_unused;
  logic [OP_W-1:0]   opcode;

  assign instr       = in_word[WORD_W-1:PATH_W];
  assign path_unused = in_word[PATH_W-1:0];
  assign opcode      = instr[INSTR_W-1 -: OP_W];
  assign kind        = classify(in_valid, in_token, opcode, TAIL_OP);

endmodule

// File: rtl/intake_epi_fifo.sv
module intake_epi_fifo #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/intake_state.sv
module intake_state
  import intake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tail_acc,
  input  logic unseal,
  input  logic tok_acc,
  input  logic kill_ack,
  output logic sealed,
  output logic kill_pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sealed       <= 1'b0;
      kill_pending <= 1'b0;
    end else begin
      sealed       <= seal_next(sealed, tail_acc, unseal);
      kill_pending <= kill_next(kill_pending, tok_acc, kill_ack);
    end
  end

endmodule

// File: rtl/intake_gate.sv
module intake_gate
  import intake_pkg::*;
#(
  parameter int unsigned INSTR_W   = DEF_INSTR_W,
  parameter int unsigned PATH_W    = DEF_PATH_W,
  parameter int unsigned EPI_DEPTH = 4,
  parameter logic [OP_W-1:0] TAIL_OP = DEF_TAIL_OP,
  localparam int unsigned WORD_W = INSTR_W + PATH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_token,
  input  logic [WORD_W-1:0]  in_word,
  output logic               in_ready,
  input  logic               unseal,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [INSTR_W-1:0] out_instr,
  output logic               kill_pending,
  input  logic               kill_ack
);

  arrival_e           kind;
  logic [INSTR_W-1:0] instr;
  logic [INSTR_W-1:0] epi_head;
  logic               sealed, epi_empty, epi_full, bypass;
  logic               word_in, tail_in, tok_in;
  logic               tail_acc, tok_acc, epi_push, epi_pop;

  intake_decode #(.INSTR_W(INSTR_W), .PATH_W(PATH_W), .TAIL_OP(TAIL_OP)) u_decode (
    .in_valid (in_valid),
    .in_token (in_token),
    .in_word  (in_word),
    .kind     (kind),
    .instr    (instr)
  );

  assign word_in = (kind == ARR_WORD);
  assign tail_in = (kind == ARR_TAIL);
  assign tok_in  = (kind == ARR_TOKEN);

  // Open gate with nothing stored: words go straight through.
  assign bypass = !sealed && epi_empty;

  always_comb begin
    unique case (kind)
      ARR_TOKEN: in_ready = !kill_pending;
      ARR_TAIL:  in_ready = sealed || epi_empty;
      default:   in_ready = bypass ? out_ready : !epi_full;
    endcase
  end

  assign tail_acc = tail_in && in_ready;
  assign tok_acc  = tok_in && in_ready;
  assign epi_push = word_in && !bypass && !epi_full;
  assign epi_pop  = !sealed && !epi_empty && out_ready;

  assign out_valid = !sealed && (!epi_empty || word_in);
  assign out_instr = epi_empty ? instr : epi_head;

  intake_epi_fifo #(.W(INSTR_W), .DEPTH(EPI_DEPTH)) u_epi (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (epi_push),
    .pop   (epi_pop),
    .din   (instr),
    .dout  (epi_head),
    .empty (epi_empty),
    .full  (epi_full)
  );

  intake_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .tail_acc     (tail_acc),
    .unseal       (unseal),
    .tok_acc      (tok_acc),
    .kill_ack     (kill_ack),
    .sealed       (sealed),
    .kill_pending (kill_pending)
  );

endmodule

// File: rtl/intake_gate_checker.sv
module intake_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_token,
  input logic in_ready,
  input logic unseal,
  input logic out_valid,
  input logic kill_pending,
  input logic kill_ack,
  input logic sealed,
  input logic tail_acc,
  input logic tok_acc,
  input logic word_in,
  input logic tail_in,
  input logic epi_full,
  input logic epi_empty
);

  AST_SEALED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !out_valid);                                          // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && epi_full && word_in) |-> !in_ready);                  // R4
  AST_TAIL_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
    tail_acc |=> sealed);                                            // R6
  AST_SEAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tail_acc && !unseal) |=> $stable(sealed));                     // R3
  AST_UNSEAL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (unseal && !tail_acc) |=> !sealed);                              // R5
  AST_TOKEN_SETS_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    tok_acc |=> kill_pending);                                       // R7
  AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pending && !kill_ack) |=> kill_pending);                   // R8
  AST_SECOND_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pending && in_valid && in_token) |-> !in_ready);           // R8
  AST_TAIL_WAITS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sealed && !epi_empty && tail_in) |-> !in_ready);               // R9

endmodule

bind intake_gate intake_gate_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_token     (in_token),
  .in_ready     (in_ready),
  .unseal       (unseal),
  .out_valid    (out_valid),
  .kill_pending (kill_pending),
  .kill_ack     (kill_ack),
  .sealed       (sealed),
  .tail_acc     (tail_acc),
  .tok_acc      (tok_acc),
  .word_in      (word_in),
  .tail_in      (tail_in),
  .epi_full     (epi_full),
  .epi_empty    (epi_empty)
);

// File: tb/intake_gate_bench.sv
`timescale 1ns/100ps
module intake_gate_bench;

  localparam int IW = 26;
  localparam int PW = 11;
  localparam int WW = IW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_token = 1'b0, unseal = 1'b0;
  logic          out_ready = 1'b0, kill_ack = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic          in_ready, out_valid, kill_pending;
  logic [IW-1:0] out_instr;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  logic [IW-1:0] q[$];
  bit m_sealed = 1'b0;
  bit m_kp = 1'b0;

  always #2.5 clk = ~clk;

  intake_gate u_intake_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_token(in_token),
    .in_word(in_word), .in_ready(in_ready), .unseal(unseal),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .kill_pending(kill_pending), .kill_ack(kill_ack)
  );

  function automatic logic [IW-1:0] instr_of(input logic [WW-1:0] w);
    return w[WW-1 -: IW];
  endfunction

  function automatic bit is_tail_w(input logic [WW-1:0] w);
    return w[WW-1 -: 2] == 2'b11;
  endfunction

  function automatic logic [WW-1:0] mk_word(input bit tail);
    logic [WW-1:0] w;
    w = {$urandom, $urandom};
    if (tail) w[WW-1 -: 2] = 2'b11;
    else if (w[WW-1 -: 2] == 2'b11) w[WW-1] = 1'b0;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard and state model, sampled 1 ns after the falling edge.
  task automatic observe();
    logic [IW-1:0] e;
    if (in_valid && in_ready && !in_token && !is_tail_w(in_word))
      q.push_back(instr_of(in_word));
    if (in_valid && in_token) chk("R7 token ready", in_ready, !m_kp);
    if (out_valid) chk("R4 no output while sealed", m_sealed, 0);
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk("R5 output with nothing expected", 1, 0);
      else begin
        e = q.pop_front();
        chk("R5 order out_instr", out_instr, e);
      end
    end
    chk("R8 kill_pending", kill_pending, m_kp);
    if (in_valid && in_ready && !in_token && is_tail_w(in_word)) m_sealed = 1'b1;
    else if (unseal) m_sealed = 1'b0;
    if (in_valid && in_ready && in_token) m_kp = 1'b1;
    else if (kill_ack) m_kp = 1'b0;
  endtask

  task automatic fin();
    observe();
    @(negedge clk);
  endtask

  task automatic tick();
    #1;
    fin();
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_token = 0; unseal = 0; kill_ack = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [WW-1:0] w;
    bit acc;
    int waited;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle_inputs(); out_ready = 1;
    #1;
    chk("R1 out_valid idle", out_valid, 0);
    chk("R1 kill_pending", kill_pending, 0);
    fin();
    w = mk_word(0);
    in_valid = 1; in_word = w;
    #1;
    chk("R1 gate open after reset", in_ready, 1);
    chk("R2 pass-through valid", out_valid, 1);
    chk("R10 instr field only", out_instr, instr_of(w));
    fin();

    // R2 back-pressure follows out_ready; R10 path bits vary
    w = mk_word(0); w[PW-1:0] = '1; in_word = w; out_ready = 0;
    #1;
    chk("R2 ready follows out_ready", in_ready, 0);
    chk("R10 out_instr with path ones", out_instr, instr_of(w));
    fin();
    out_ready = 1;
    tick();

    // R3 tail accepted and sealed
    in_word = mk_word(1);
    #1;
    chk("R3 tail ready", in_ready, 1);
    chk("R3 tail not output", out_valid, 0);
    fin();

    // R4 four words fill the buffer while sealed
    for (int i = 0; i < 4; i++) begin
      in_word = mk_word(0);
      #1;
      chk("R4 sealed no output", out_valid, 0);
      chk("R4 stored ready", in_ready, 1);
      fin();
    end
    in_word = mk_word(0);
    #1;
    chk("R4 full ready low", in_ready, 0);
    fin();

    // R7 token accepted with sealed full buffer
    in_token = 1;
    #1;
    chk("R7 token accepted when full", in_ready, 1);
    fin();
    in_valid = 0; in_token = 0;
    #1;
    chk("R7 kill_pending set", kill_pending, 1);
    chk("R7 token not output", out_valid, 0);
    fin();
    in_valid = 1; in_token = 1;
    #1;
    chk("R8 second token held", in_ready, 0);
    fin();
    in_valid = 0; in_token = 0;
    repeat (3) tick();
    kill_ack = 1;
    #1;
    chk("R8 pending during ack cycle", kill_pending, 1);
    fin();
    kill_ack = 0;
    #1;
    chk("R8 cleared after ack", kill_pending, 0);
    fin();

    // R6 tail plus unseal in one cycle keeps the gate sealed
    in_valid = 1; in_word = mk_word(1); unseal = 1;
    #1;
    chk("R6 tail ready while sealed", in_ready, 1);
    fin();
    idle_inputs();
    #1;
    chk("R6 still sealed", out_valid, 0);
    fin();

    // R5 unseal drains in order, new word queues behind
    unseal = 1;
    #1;
    chk("R5 sealed during pulse", out_valid, 0);
    fin();
    unseal = 0;
    in_valid = 1; w = mk_word(0); in_word = w;
    #1;
    chk("R5 open next cycle", out_valid, 1);
    chk("R5 full buffer holds new word", in_ready, 0);
    fin();
    acc = 0;
    for (int i = 0; i < 10 && !acc; i++) begin
      #1;
      acc = in_ready;
      fin();
    end
    chk("R5 new word eventually taken", acc, 1);
    idle_inputs();
    repeat (6) tick();
    chk("R5 all drained", q.size(), 0);

    // R9 tail held while open gate still has stored words
    in_valid = 1; in_word = mk_word(1);
    tick();
    in_word = mk_word(0); tick();
    in_word = mk_word(0); tick();
    in_valid = 0; unseal = 1; out_ready = 0;
    tick();
    unseal = 0; in_valid = 1; in_word = mk_word(1);
    #1;
    chk("R9 tail held", in_ready, 0);
    fin();
    out_ready = 1; waited = 0; acc = 0;
    for (int i = 0; i < 10 && !acc; i++) begin
      #1;
      acc = in_ready;
      if (!acc) waited++;
      fin();
    end
    chk("R9 tail waits two drain cycles", waited, 2);
    idle_inputs(); unseal = 1; tick(); unseal = 0;

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(99);
      in_valid  = ($urandom_range(99) < 70);
      in_token  = (r < 5);
      in_word   = mk_word(r >= 5 && r < 13);
      unseal    = ($urandom_range(99) < 10);
      kill_ack  = ($urandom_range(99) < 30);
      out_ready = ($urandom_range(99) < 60);
      tick();
    end

    idle_inputs(); unseal = 1; tick(); unseal = 0;
    out_ready = 1;
    kill_ack = 1; tick(); kill_ack = 0;
    repeat (8) tick();
    chk("R5 final drain", q.size(), 0);
    summary();
  end

endmodule